// File: doc/BRIEF.md
# Central/Satellite Timer Synchronizer

This block keeps one central 64-bit count and a set of per-cluster satellite 64-bit counts. Each satellite is brought into exact agreement with the central count by a short software sequence. First, a read of the cluster's arm register returns the central low word and starts that satellite from zero. The same read captures the central high word for later. Software then reads the captured high word. Finally it writes a 64-bit increment into the satellite, low half first. The high-half write commits the whole sum in one cycle.

The satellite's start passes through one register stage that stands in for the interconnect path. Because of that stage and the start from zero, software adds 2 to the sampled low word. If that addition carries out of 32 bits, software adds 1 to the high word. A global run register gates every satellite's count enable. It can be written only when the upper 24 bits of the write data carry the key 0xACCE55.

A release bit holds the whole synchronizer in reset until software sets it. Both counts are exposed on ports for checking.

Top module: `tsync_top`

## Requirements
- R1: While the release bit (byte address 0x000, bit 0) reads 0, the central count holds the preset value `CNT_PRESET` and every satellite holds 0. Both take those values one cycle after the bit is cleared.
- R2: While released, the central count rises by exactly one on every clock.
- R3: A read of arm register k (address 0x010 + 4k) returns bits [31:0] of the central count as it stood when the request was accepted. The same read latches bits [63:32] into the hold register.
- R4: If a read of arm register k is accepted at edge t, satellite k reads 0 after edge t+1. From then on it counts up by one per clock.
- R5: A read of the central-low register (0x008) returns the live low word and latches the high word. A read of the central-high register (0x00C) returns the latched word, even after the live high word has moved on.
- R6: A write to the run register (0x004) with bits [31:8] = 0xACCE55 sets each satellite k's run bit to data bit k. A satellite whose run bit is 0 holds its value. The run register reads back the run bits.
- R7: A write to the run register with any other key changes no run bit, and the satellites keep counting.
- R8: Writing the increment-low register of satellite k (0x100 + 0x20k + 0x14) stores the word, which reads back at that address. The write leaves the satellite count unchanged apart from its normal step.
- R9: Writing the increment-high register of satellite k (0x100 + 0x20k + 0x18) adds {written word, stored low word} to the satellite in one cycle, on top of its normal step.
- R10: Consider an arm read of k, a read of 0x00C, then writes of low+2 and of high (or high+1 when low >= 2^32-2). After that sequence, satellite k equals the central count exactly, both with and without the low-word wrap.
- R11: Read data is valid exactly in the cycle after a read is accepted. A read of an unmapped address returns 0. The satellite status word (0x100 + 0x20k) returns the run bit in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request accepted at this edge |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| central_cnt | output | 64 | Central count |
| sat_cnt | output | NUM_SAT*64 | Satellite counts, satellite k in bits [64k+63:64k] |

## Verification
Register writes take effect at the edge that accepts them, and read data appears one cycle later. The bench drives each request on a falling edge and samples on the next falling edge. At that point the written state and the returned word are both settled. The satellite clear lands one edge after the arm read, so the zero check is made after the following request has completed. The increment lands on the edge of the high-half write, so equality with the central count is checked at the falling edge right after that write, and again some cycles later. The release, freeze and clear effects need one extra edge, and the bench waits one more falling edge before checking them.

// File: rtl/tsync_pkg.sv
package tsync_pkg;
  localparam int DW = 32;
  localparam int CW = 2 * DW;
  localparam logic [23:0] RUN_KEY = 24'hACCE55;

  localparam int A_REL   = 'h000;
  localparam int A_RUN   = 'h004;
  localparam int A_CLO   = 'h008;
  localparam int A_CHI   = 'h00C;
  localparam int A_ARM0  = 'h010;
  localparam int A_SAT0  = 'h100;
  localparam int SAT_STRIDE = 'h20;
  localparam int OFF_STAT = 'h00;
  localparam int OFF_LO   = 'h14;
  localparam int OFF_HI   = 'h18;

  function automatic int arm_addr(input int k);
    return A_ARM0 + 4 * k;
  endfunction

  function automatic int sat_addr(input int k, input int off);
    return A_SAT0 + SAT_STRIDE * k + off;
  endfunction
endpackage

// File: rtl/tsync_central.sv
module tsync_central
  import tsync_pkg::*;
#(
  parameter logic [CW-1:0] PRESET = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rel,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!rel) cnt_d = PRESET;
    else      cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= PRESET;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/tsync_sat.sv
module tsync_sat
  import tsync_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rel,
  input  logic          run,
  input  logic          start_req,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [DW-1:0] wdata,
  output logic [CW-1:0] cnt,
  output logic [DW-1:0] lo
);
  logic          start_q, start_d;
  logic [DW-1:0] lo_q, lo_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] inc;

  always_comb begin
    start_d = start_req;
    lo_d    = wr_lo ? wdata : lo_q;
    inc     = wr_hi ? {wdata, lo_q} : '0;
    cnt_d   = cnt_q + CW'(run) + inc;
    if (start_q) cnt_d = '0;
    if (!rel) begin
      start_d = 1'b0;
      lo_d    = '0;
      cnt_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      lo_q    <= '0;
      cnt_q   <= '0;
    end else begin
      start_q <= start_d;
      lo_q    <= lo_d;
      cnt_q   <= cnt_d;
    end
  end

  assign cnt = cnt_q;
  assign lo  = lo_q;
endmodule

// File: rtl/tsync_regif.sv
module tsync_regif
  import tsync_pkg::*;
#(
  parameter int NUM_SAT = 2,
  parameter int ADDR_W  = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_wr,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DW-1:0]         req_wdata,
  input  logic [CW-1:0]         cnt_now,
  input  logic [NUM_SAT*DW-1:0] sat_lo,
  output logic                  rel,
  output logic [NUM_SAT-1:0]    run,
  output logic [NUM_SAT-1:0]    start_req,
  output logic [NUM_SAT-1:0]    wr_lo,
  output logic [NUM_SAT-1:0]    wr_hi,
  output logic                  rd_valid,
  output logic [DW-1:0]         rd_data
);
  logic               rel_q, rel_d;
  logic [NUM_SAT-1:0] run_q, run_d;
  logic [DW-1:0]      hold_q, hold_d;
  logic [DW-1:0]      rdat_q, rdat_d;
  logic               rval_q, rval_d;
  logic               rd_acc, wr_acc, key_ok;
  logic [NUM_SAT-1:0] arm_hit;

  assign rd_acc = req_valid && !req_wr;
  assign wr_acc = req_valid && req_wr;
  assign key_ok = (req_wdata[DW-1:8] == RUN_KEY);

  always_comb begin
    rel_d  = rel_q;
    run_d  = run_q;
    hold_d = hold_q;
    if (wr_acc && req_addr == ADDR_W'(A_REL)) rel_d = req_wdata[0];
    if (wr_acc && req_addr == ADDR_W'(A_RUN) && key_ok) run_d = req_wdata[NUM_SAT-1:0];
    if (rd_acc && req_addr == ADDR_W'(A_CLO)) hold_d = cnt_now[CW-1:DW];
    for (int k = 0; k < NUM_SAT; k++) begin
      arm_hit[k] = rd_acc && (req_addr == ADDR_W'(arm_addr(k)));
      wr_lo[k]   = rel_q && wr_acc && (req_addr == ADDR_W'(sat_addr(k, OFF_LO)));
      wr_hi[k]   = rel_q && wr_acc && (req_addr == ADDR_W'(sat_addr(k, OFF_HI)));
      if (arm_hit[k]) begin
        run_d[k] = 1'b1;
        hold_d   = cnt_now[CW-1:DW];
      end
    end
    start_req = arm_hit & {NUM_SAT{rel_q}};
    if (!rel_q) begin
      run_d  = '0;
      hold_d = '0;
    end
  end

  always_comb begin
    rval_d = rd_acc;
    rdat_d = '0;
    if (rd_acc) begin
      if (req_addr == ADDR_W'(A_REL)) rdat_d = DW'(rel_q);
      if (req_addr == ADDR_W'(A_RUN)) rdat_d = DW'(run_q);
      if (req_addr == ADDR_W'(A_CLO)) rdat_d = cnt_now[DW-1:0];
      if (req_addr == ADDR_W'(A_CHI)) rdat_d = hold_q;
      for (int k = 0; k < NUM_SAT; k++) begin
        if (arm_hit[k]) rdat_d = cnt_now[DW-1:0];
        if (req_addr == ADDR_W'(sat_addr(k, OFF_STAT))) rdat_d = DW'(run_q[k]);
        if (req_addr == ADDR_W'(sat_addr(k, OFF_LO)))   rdat_d = sat_lo[k*DW +: DW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_q  <= 1'b0;
      run_q  <= '0;
      hold_q <= '0;
      rdat_q <= '0;
      rval_q <= 1'b0;
    end else begin
      rel_q  <= rel_d;
      run_q  <= run_d;
      hold_q <= hold_d;
      rdat_q <= rdat_d;
      rval_q <= rval_d;
    end
  end

  assign rel      = rel_q;
  assign run      = run_q;
  assign rd_valid = rval_q;
  assign rd_data  = rdat_q;
endmodule

// File: rtl/tsync_top.sv
module tsync_top
  import tsync_pkg::*;
#(
  parameter int              NUM_SAT    = 2,
  parameter int              ADDR_W     = 12,
  parameter logic [CW-1:0]   CNT_PRESET = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_wr,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DW-1:0]         req_wdata,
  output logic                  rd_valid,
  output logic [DW-1:0]         rd_data,
  output logic [CW-1:0]         central_cnt,
  output logic [NUM_SAT*CW-1:0] sat_cnt
);
  logic [1:0]            rst_pipe;
  logic                  rst_sync_n;
  logic                  released;
  logic [NUM_SAT-1:0]    run, start_req, wr_lo, wr_hi;
  logic [NUM_SAT*DW-1:0] sat_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  tsync_regif #(.NUM_SAT(NUM_SAT), .ADDR_W(ADDR_W)) u_regif (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_wr    (req_wr),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .cnt_now   (central_cnt),
    .sat_lo    (sat_lo),
    .rel       (released),
    .run       (run),
    .start_req (start_req),
    .wr_lo     (wr_lo),
    .wr_hi     (wr_hi),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  tsync_central #(.PRESET(CNT_PRESET)) u_central (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .rel   (released),
    .cnt   (central_cnt)
  );

  for (genvar k = 0; k < NUM_SAT; k++) begin : g_sat
    tsync_sat u_sat (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .rel       (released),
      .run       (run[k]),
      .start_req (start_req[k]),
      .wr_lo     (wr_lo[k]),
      .wr_hi     (wr_hi[k]),
      .wdata     (req_wdata),
      .cnt       (sat_cnt[k*CW +: CW]),
      .lo        (sat_lo[k*DW +: DW])
    );
  end
endmodule

// File: rtl/tsync_chk.sv
module tsync_chk
  import tsync_pkg::*;
#(
  parameter int            NUM_SAT = 2,
  parameter int            ADDR_W  = 12,
  parameter logic [CW-1:0] PRESET  = '0
) (
  input logic                  clk,
  input logic                  rst_ok,
  input logic                  rel,
  input logic                  req_valid,
  input logic                  req_wr,
  input logic [ADDR_W-1:0]     req_addr,
  input logic                  rd_valid,
  input logic [CW-1:0]         central_cnt,
  input logic [NUM_SAT*CW-1:0] sat_cnt
);
  assert_preset_hold_R1: assert property (@(posedge clk) disable iff (!rst_ok)
    (!rel && !$past(rel)) |-> (central_cnt == PRESET && sat_cnt == '0));

  assert_central_step_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    (rel && $past(rel)) |-> (central_cnt == $past(central_cnt) + CW'(1)));

  assert_read_valid_R11: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_valid && !req_wr) |=> rd_valid);

  assert_read_idle_R11: assert property (@(posedge clk) disable iff (!rst_ok)
    !(req_valid && !req_wr) |=> !rd_valid);

  for (genvar k = 0; k < NUM_SAT; k++) begin : g_arm
    assert_arm_clear_R4: assert property (@(posedge clk) disable iff (!rst_ok)
      (rel && req_valid && !req_wr && req_addr == ADDR_W'(arm_addr(k)))
      |=> ##1 (sat_cnt[k*CW +: CW] == '0));
  end
endmodule

bind tsync_top tsync_chk #(.NUM_SAT(NUM_SAT), .ADDR_W(ADDR_W), .PRESET(CNT_PRESET)) u_chk (
  .clk         (clk),
  .rst_ok      (rst_sync_n),
  .rel         (released),
  .req_valid   (req_valid),
  .req_wr      (req_wr),
  .req_addr    (req_addr),
  .rd_valid    (rd_valid),
  .central_cnt (central_cnt),
  .sat_cnt     (sat_cnt)
);

// File: tb/test_tsync_top.sv
module test_tsync_top;
  import tsync_pkg::*;

  localparam int            NS  = 2;
  localparam int            AW  = 12;
  localparam logic [63:0]   PRE = 64'h0000_0005_FFFF_FF00;

  logic          clk, rst_n, req_valid, req_wr;
  logic [AW-1:0] req_addr;
  logic [31:0]   req_wdata, rd_data;
  logic          rd_valid;
  logic [63:0]   central_cnt;
  logic [NS*64-1:0] sat_cnt;
  int checks = 0, failures = 0;
  bit done = 0;

  tsync_top #(.NUM_SAT(NS), .ADDR_W(AW), .CNT_PRESET(PRE)) i_tsync_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .central_cnt(central_cnt), .sat_cnt(sat_cnt));

  initial clk = 0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic        chk;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 12'h004, 32'h1234_5603, 1'b0, 32'h0, 4'd7},  // R7 bad key
    '{1'b0, 12'h004, 32'h0,         1'b1, 32'h0, 4'd7},  // R7 unchanged
    '{1'b1, 12'h004, 32'hACCE_5503, 1'b0, 32'h0, 4'd6},  // R6 keyed set
    '{1'b0, 12'h004, 32'h0,         1'b1, 32'h3, 4'd6},  // R6
    '{1'b0, 12'h100, 32'h0,         1'b1, 32'h1, 4'd11}, // R11 status
    '{1'b1, 12'h004, 32'hACCE_5500, 1'b0, 32'h0, 4'd6},  // R6 keyed clear
    '{1'b0, 12'h004, 32'h0,         1'b1, 32'h0, 4'd6},  // R6
    '{1'b0, 12'h0FC, 32'h0,         1'b1, 32'h0, 4'd11}, // R11 unmapped
    '{1'b0, 12'h000, 32'h0,         1'b1, 32'h1, 4'd1},  // R1 release bit
    '{1'b1, 12'h114, 32'hCAFE_0001, 1'b0, 32'h0, 4'd8},  // R8
    '{1'b0, 12'h114, 32'h0,         1'b1, 32'hCAFE_0001, 4'd8},
    '{1'b1, 12'h134, 32'h0000_0077, 1'b0, 32'h0, 4'd8},
    '{1'b0, 12'h134, 32'h0,         1'b1, 32'h0000_0077, 4'd8}
  };

  function automatic logic [63:0] sat(input int k);
    return sat_cnt[k*64 +: 64];
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic [11:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output logic rv);
    req_valid = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    rd = rd_data; rv = rd_valid;
    req_valid = 1'b0; req_wr = 1'b0;
  endtask

  task automatic sync_sat(input int k, input string tag);
    logic [31:0] lo, hi, r;
    logic [63:0] c0;
    logic v;
    c0 = central_cnt;
    bus(1'b0, 12'(arm_addr(k)), 32'h0, lo, v);
    chk({tag, " R3 arm low"}, {32'h0, lo}, {32'h0, c0[31:0]});
    bus(1'b0, 12'(A_CHI), 32'h0, hi, v);
    chk({tag, " R3 latched high"}, {32'h0, hi}, {32'h0, c0[63:32]});
    chk({tag, " R4 cleared"}, sat(k), 64'h0);
    bus(1'b1, 12'(sat_addr(k, OFF_LO)), lo + 32'd2, r, v);
    bus(1'b1, 12'(sat_addr(k, OFF_HI)), (lo >= 32'hFFFF_FFFE) ? hi + 32'd1 : hi, r, v);
    chk({tag, " R10 aligned"}, sat(k), central_cnt);
    repeat (7) @(negedge clk);
    chk({tag, " R10 still aligned"}, sat(k), central_cnt);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic v;
    logic [63:0] a, s;
    rst_n = 0; req_valid = 0; req_wr = 0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 central preset", central_cnt, PRE);
    chk("R1 sats zero", sat_cnt[63:0] | sat_cnt[127:64], 64'h0);
    chk("R11 idle rd_valid", {63'h0, rd_valid}, 64'h0);
    repeat (3) @(negedge clk);
    chk("R1 central still preset", central_cnt, PRE);

    bus(1'b1, 12'(A_REL), 32'h1, r, v);
    a = central_cnt;
    repeat (5) @(negedge clk);
    chk("R2 five steps", central_cnt, a + 64'd5);

    for (int i = 0; i < NV; i++) begin
      bus(VEC[i].wr, VEC[i].addr, VEC[i].wdata, r, v);
      chk($sformatf("R11 valid row %0d", i), {63'h0, v}, {63'h0, ~VEC[i].wr});
      if (VEC[i].chk)
        chk($sformatf("R%0d table row %0d", VEC[i].req, i), {32'h0, r}, {32'h0, VEC[i].exp});
    end

    a = central_cnt;
    bus(1'b0, 12'(A_CLO), 32'h0, r, v);
    chk("R5 central low read", {32'h0, r}, {32'h0, a[31:0]});

    sync_sat(0, "sat0 no-wrap");

    while (central_cnt[31:0] != 32'hFFFF_FFFE) @(negedge clk);
    sync_sat(1, "sat1 wrap");
    chk("R10 wrap reached", {32'h0, central_cnt[63:32]}, 64'h6);
    chk("R10 sat0 after wrap", sat(0), central_cnt);

    bus(1'b0, 12'(A_CHI), 32'h0, r, v);
    chk("R5 hold not live", {32'h0, r}, 64'h5);

    bus(1'b1, 12'(A_RUN), 32'hACCE_5501, r, v);
    s = sat(1);
    repeat (3) @(negedge clk);
    chk("R6 sat1 frozen", sat(1), s);
    chk("R6 sat0 running", sat(0), central_cnt);

    bus(1'b1, 12'(A_RUN), 32'h1234_5600, r, v);
    repeat (2) @(negedge clk);
    chk("R7 sat0 keeps counting", sat(0), central_cnt);
    bus(1'b0, 12'(A_RUN), 32'h0, r, v);
    chk("R7 run bits kept", {32'h0, r}, 64'h1);

    bus(1'b1, 12'(sat_addr(1, OFF_LO)), 32'h0000_0010, r, v);
    chk("R8 low write no effect", sat(1), s);
    bus(1'b1, 12'(sat_addr(1, OFF_HI)), 32'h0000_0001, r, v);
    chk("R9 single-cycle add", sat(1), s + 64'h1_0000_0010);

    a = sat(0);
    bus(1'b1, 12'(sat_addr(0, OFF_LO)), 32'h0000_0100, r, v);
    bus(1'b1, 12'(sat_addr(0, OFF_HI)), 32'h0000_0000, r, v);
    chk("R9 add with step", sat(0), a + 64'd2 + 64'h100);

    bus(1'b1, 12'(A_REL), 32'h0, r, v);
    @(negedge clk);
    chk("R1 central back to preset", central_cnt, PRE);
    chk("R1 sats cleared", sat_cnt[63:0] | sat_cnt[127:64], 64'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule